// File: doc/BRIEF.md
# Offset-Addressed Trie Longest-Prefix Lookup Engine

This engine finds the longest matching prefix of an IP address by walking a compact multi-bit trie kept in an internal node memory. Each node word carries only two things: a bitmap with one flag per possible stride value, and a small offset. The engine has no stored child or next-hop pointers. It works out every child's memory location from the current node's location, the offset, and a count of the clear bitmap flags that lie below the selected index. The trie is leaf-pushed. A set flag means the selected child is a prefix, so the search ends there. A clear flag means the child is an interior node, and the search moves on to it.

A lookup starts with a one-cycle `start` pulse while the engine is idle. The engine reads one node per clock from a synchronous RAM. When it finishes, it pulses `done` and presents the hit flag, the matched address bits and the matched length. These results stay in place until the next lookup completes. A write port lets the surrounding logic load the trie image while no lookup is running. Turning the matched prefix into a next hop is left to a separate table outside this block.

Top module: `oet_lookup`

## Requirements
- R1: After reset, `busy`, `done`, `hit`, `matchLen` and `matchPrefix` are all zero.
- R2: Every lookup begins at node address 1. If the root's flag for the first stride is set, the lookup completes with length STRIDE after one node read.
- R3: Address bits are consumed most significant first, STRIDE bits per step. The step value v selects bitmap flag v, and flag v is bit v of the node word.
- R4: A node word keeps its 2^STRIDE-bit bitmap in its low bits and its offset in the OFF_W bits directly above them.
- R5: When the selected flag is clear, the next node address is the current address plus the offset plus the number of clear flags at indices below the selected one, taken modulo the node memory depth.
- R6: On a hit after k node reads, `matchLen` equals k*STRIDE and `matchPrefix` equals the address with every bit below its top k*STRIDE bits cleared.
- R7: If all ADDR_W/STRIDE steps are used up without reaching a set flag, the lookup completes with `hit`=0, `matchLen`=0 and `matchPrefix`=0.
- R8: `done` is a one-cycle pulse that comes exactly k cycles after the start edge for a lookup of k node reads. `busy` is high from the cycle after the start edge until `done` rises.
- R9: A `start` pulse while `busy` is high is ignored and has no effect on the lookup in progress.
- R10: `hit`, `matchLen` and `matchPrefix` stay unchanged between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup of `ipAddr` when idle |
| ipAddr | input | ADDR_W | Address to be searched |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | A prefix matched |
| matchPrefix | output | ADDR_W | Matched address bits, left-aligned, with the lower bits zero |
| matchLen | output | $clog2(ADDR_W+1) | Matched prefix length in bits |
| memWrEn | input | 1 | Node memory write enable |
| memWrAddr | input | NODE_AW | Node memory write address |
| memWrData | input | 2^STRIDE+OFF_W | Node word: {offset, bitmap} |

## Verification
The hardest condition to reach from the ports is a lookup that runs all the way to the last stride without matching. A random trie almost always hits long before that. The stimulus therefore loads an all-zero trie image, which forces every walk to use its full sixteen steps. That same long walk is where a second `start` is injected partway through, to show it is ignored. Random trie images with sparse set flags and random offsets then cover the address arithmetic, including wrap-around of the node address.

// File: rtl/oet_pkg.sv
package oet_pkg;
  // strobes from the walk controller to the datapath
  typedef struct packed {
    logic load;    // capture address, read root
    logic step;    // descend to the computed child
    logic finish;  // register the result
    logic hit;     // result is a match (valid with finish)
  } oetCtrl_t;
endpackage

// File: rtl/oet_node_ram.sv
module oet_node_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/oet_datapath.sv
module oet_datapath
  import oet_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STRIDE  = 2,
  parameter int NODE_AW = 6,
  parameter int OFF_W   = 4,
  localparam int BM_W   = 1 << STRIDE,
  localparam int WORD_W = BM_W + OFF_W,
  localparam int NSTEPS = ADDR_W / STRIDE,
  localparam int DEP_W  = (NSTEPS > 1) ? $clog2(NSTEPS) : 1,
  localparam int LEN_W  = $clog2(ADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  oetCtrl_t           ctrl,
  input  logic [ADDR_W-1:0]  ipAddr,
  input  logic [WORD_W-1:0]  rdData,
  output logic [NODE_AW-1:0] rdAddr,
  output logic               bitSet,
  output logic               lastStep,
  output logic               hit,
  output logic [ADDR_W-1:0]  matchPrefix,
  output logic [LEN_W-1:0]   matchLen
);
  localparam logic [NODE_AW-1:0] ROOT = NODE_AW'(1);

  logic [NODE_AW-1:0] curAddr, nextAddr;
  logic [ADDR_W-1:0]  ipReg, shAddr;
  logic [DEP_W-1:0]   depth;
  logic [BM_W-1:0]    nodeBm;
  logic [OFF_W-1:0]   nodeOff;
  logic [STRIDE-1:0]  idx;
  logic [STRIDE:0]    zeroCnt;
  logic [LEN_W-1:0]   hitLen;

  assign nodeBm  = rdData[BM_W-1:0];
  assign nodeOff = rdData[BM_W +: OFF_W];
  assign idx     = shAddr[ADDR_W-1 -: STRIDE];
  assign bitSet  = nodeBm[idx];
  assign lastStep = (depth == DEP_W'(NSTEPS - 1));

  // clear flags below the selected index
  always_comb begin
    zeroCnt = '0;
    for (int i = 0; i < BM_W; i++) begin
      if ((i < int'(idx)) && !nodeBm[i]) zeroCnt = zeroCnt + 1'b1;
    end
  end

  assign nextAddr = curAddr + NODE_AW'(nodeOff) + NODE_AW'(zeroCnt);
  assign rdAddr   = ctrl.load ? ROOT : nextAddr;
  assign hitLen   = LEN_W'((int'(depth) + 1) * STRIDE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curAddr     <= '0;
      ipReg       <= '0;
      shAddr      <= '0;
      depth       <= '0;
      hit         <= 1'b0;
      matchPrefix <= '0;
      matchLen    <= '0;
    end else begin
      if (ctrl.load) begin
        curAddr <= ROOT;
        ipReg   <= ipAddr;
        shAddr  <= ipAddr;
        depth   <= '0;
      end else if (ctrl.step) begin
        curAddr <= nextAddr;
        shAddr  <= shAddr << STRIDE;
        depth   <= depth + 1'b1;
      end
      if (ctrl.finish) begin
        hit         <= ctrl.hit;
        matchLen    <= ctrl.hit ? hitLen : '0;
        matchPrefix <= ctrl.hit ? (ipReg & ~({ADDR_W{1'b1}} >> hitLen)) : '0;
      end
    end
  end
endmodule

// File: rtl/oet_ctrl.sv
module oet_ctrl
  import oet_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     bitSet,
  input  logic     lastStep,
  output oetCtrl_t ctrl,
  output logic     busy,
  output logic     done
);
  typedef enum logic {ST_IDLE, ST_WALK} state_t;
  state_t state;

  always_comb begin
    ctrl = '0;
    if (state == ST_IDLE) begin
      ctrl.load = start;
    end else if (bitSet) begin
      ctrl.finish = 1'b1;
      ctrl.hit    = 1'b1;
    end else if (lastStep) begin
      ctrl.finish = 1'b1;
    end else begin
      ctrl.step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.load)        state <= ST_WALK;
      else if (ctrl.finish) state <= ST_IDLE;
    end
  end

  assign busy = (state == ST_WALK);
endmodule

// File: rtl/oet_lookup.sv
module oet_lookup
  import oet_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STRIDE  = 2,
  parameter int NODE_AW = 6,
  parameter int OFF_W   = 4,
  localparam int WORD_W = (1 << STRIDE) + OFF_W,
  localparam int LEN_W  = $clog2(ADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  ipAddr,
  output logic               busy,
  output logic               done,
  output logic               hit,
  output logic [ADDR_W-1:0]  matchPrefix,
  output logic [LEN_W-1:0]   matchLen,
  input  logic               memWrEn,
  input  logic [NODE_AW-1:0] memWrAddr,
  input  logic [WORD_W-1:0]  memWrData
);
  oetCtrl_t           ctrl;
  logic [NODE_AW-1:0] rdAddr;
  logic [WORD_W-1:0]  rdData;
  logic               bitSet, lastStep;

  oet_node_ram #(.AW(NODE_AW), .DW(WORD_W)) u_ram (
    .clk(clk), .wrEn(memWrEn), .wrAddr(memWrAddr), .wrData(memWrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  oet_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bitSet(bitSet),
    .lastStep(lastStep), .ctrl(ctrl), .busy(busy), .done(done)
  );

  oet_datapath #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .NODE_AW(NODE_AW), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ipAddr(ipAddr), .rdData(rdData),
    .rdAddr(rdAddr), .bitSet(bitSet), .lastStep(lastStep), .hit(hit),
    .matchPrefix(matchPrefix), .matchLen(matchLen)
  );
endmodule

// File: rtl/oet_lookup_chk.sv
module oet_lookup_chk #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 2,
  localparam int LEN_W = $clog2(ADDR_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              hit,
  input logic [ADDR_W-1:0] matchPrefix,
  input logic [LEN_W-1:0]  matchLen
);
  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: an accepted start makes the engine busy
  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8: done rises exactly as busy falls
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7: a miss reports zero length and zero prefix
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (matchLen == '0 && matchPrefix == '0));

  // R6: a hit length is a nonzero whole number of strides
  p_hit_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (matchLen != '0 && int'(matchLen) <= ADDR_W
                       && (int'(matchLen) % STRIDE) == 0));

  // R10: results hold between completions
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(matchLen) && $stable(matchPrefix) && $stable(hit)));
endmodule

bind oet_lookup oet_lookup_chk #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .hit(hit), .matchPrefix(matchPrefix), .matchLen(matchLen)
);

// File: tb/oet_lookup_tb.sv
module oet_lookup_tb;
  localparam int ADDR_W  = 32;
  localparam int STRIDE  = 2;
  localparam int NODE_AW = 6;
  localparam int OFF_W   = 4;
  localparam int BM_W    = 1 << STRIDE;
  localparam int WORD_W  = BM_W + OFF_W;
  localparam int LEN_W   = $clog2(ADDR_W + 1);
  localparam int DEPTH   = 1 << NODE_AW;
  localparam int NSTEPS  = ADDR_W / STRIDE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] ipAddr = '0;
  logic busy, done, hit;
  logic [ADDR_W-1:0] matchPrefix;
  logic [LEN_W-1:0] matchLen;
  logic memWrEn = 1'b0;
  logic [NODE_AW-1:0] memWrAddr = '0;
  logic [WORD_W-1:0] memWrData = '0;

  int checks = 0;
  int fails = 0;
  logic [WORD_W-1:0] mirror [DEPTH];

  always #4 clk = ~clk;

  oet_lookup #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .NODE_AW(NODE_AW), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ipAddr(ipAddr), .busy(busy),
    .done(done), .hit(hit), .matchPrefix(matchPrefix), .matchLen(matchLen),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [BM_W-1:0] bm, input logic [OFF_W-1:0] off);
    @(negedge clk);
    memWrEn = 1'b1;
    memWrAddr = NODE_AW'(a);
    memWrData = {off, bm};  // R4 layout
    mirror[a] = {off, bm};
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  // reference walk from the requirements (R2, R3, R5, R6, R7)
  function automatic void refWalk(input logic [ADDR_W-1:0] a, output bit eHit,
                                  output int eLen, output int eReads);
    int cur = 1;
    eHit = 0; eLen = 0; eReads = 0;
    for (int s = 0; s < NSTEPS; s++) begin
      logic [BM_W-1:0] bm;
      int off, v, z;
      bm  = mirror[cur][BM_W-1:0];
      off = int'(mirror[cur][WORD_W-1:BM_W]);
      v   = int'((a >> (ADDR_W - STRIDE*(s+1))) & ((1 << STRIDE) - 1));
      eReads = s + 1;
      if (bm[v]) begin
        eHit = 1; eLen = (s + 1) * STRIDE;
        return;
      end
      z = 0;
      for (int i = 0; i < v; i++) if (!bm[i]) z++;
      cur = (cur + off + z) % DEPTH;
    end
  endfunction

  function automatic logic [ADDR_W-1:0] maskTop(input logic [ADDR_W-1:0] a, input int len);
    logic [ADDR_W-1:0] m = '0;
    for (int i = 0; i < ADDR_W; i++) if (i >= ADDR_W - len) m[i] = 1'b1;
    return a & m;
  endfunction

  // run a lookup; optionally pulse start again after 'intrAt' cycles
  task automatic lookup(input logic [ADDR_W-1:0] a, input int intrAt, input string tag);
    bit eHit; int eLen, eReads, n;
    refWalk(a, eHit, eLen, eReads);
    @(negedge clk);
    start = 1'b1; ipAddr = a;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      if (n == intrAt && !done) begin
        start = 1'b1; ipAddr = ~a;
        @(negedge clk);
        start = 1'b0;
        n++;
      end
    end
    chk(n == eReads, {tag, " R8 latency"}, n, eReads);
    chk(hit == eHit, {tag, (eHit ? " R6 hit" : " R7 hit")}, hit, eHit);
    chk(int'(matchLen) == eLen, {tag, (eHit ? " R6 len" : " R7 len")}, matchLen, eLen);
    chk(matchPrefix == maskTop(a, eLen), {tag, " R6 prefix"}, matchPrefix, maskTop(a, eLen));
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [LEN_W-1:0] hl; logic [ADDR_W-1:0] hp;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !hit, "R1 flags", {busy, done, hit}, 0);
    chk(matchLen == 0 && matchPrefix == 0, "R1 result", matchLen, 0);
    rst_n = 1'b1;

    // all-zero trie: full walk without match (R7), start during walk ignored (R9)
    for (int i = 0; i < DEPTH; i++) wr(i, '0, '0);
    lookup(32'h9A5C_3E71, 0, "zero");
    lookup(32'h1234_5678, 5, "R9 restart");
    chk(!busy, "R9 idle after", busy, 0);

    // directed: root at 1 (R2), flag v at bit v (R3), layout (R4), child address (R5)
    wr(1, 4'b0110, 4'd1);
    wr(3, 4'b0100, 4'd0);
    wr(2, 4'b0001, 4'd0);
    lookup(32'hE000_0000, 0, "R5 child3");     // 11 -> node 3, 10 hit: len 4
    lookup(32'h4000_0000, 0, "R3 root01");     // flag1 set at root
    lookup(32'h8000_0000, 0, "R2 root10");     // flag2 set at root
    lookup(32'h0000_0000, 0, "R5 child2");     // 00 -> node 2, 00 hit
    // R10: results hold after completion
    hl = matchLen; hp = matchPrefix;
    repeat (5) @(negedge clk);
    chk(matchLen == hl && matchPrefix == hp && hit, "R10 hold", matchLen, hl);

    // random tries
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [BM_W-1:0] bm;
        for (int b = 0; b < BM_W; b++) bm[b] = (($urandom % 5) == 0);
        wr(i, bm, OFF_W'($urandom));
      end
      for (int k = 0; k < 40; k++) lookup($urandom, 0, "rand R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule